// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block converts one-word requests from a controller into the multi-cycle bus-write sequences that a standard parallel NOR flash device needs. A requester presents an opcode, a target offset and a write word. The block either accepts the request or rejects it, and then runs the matching sequence on an asynchronous memory bus. The bus has address, write data, read data, chip-enable, write-enable and output-enable, all active-low where applicable. Each bus cycle carries exactly one write strobe or one read strobe. The supported operations are read-ID, return-to-read, single-word program, sector erase, chip erase and CFI query.

A 2-bit bank select chooses one of four equal bank regions; the bank select forms the top two address bits. A width input chooses 8-bit or 16-bit device addressing. In 16-bit mode every command word address is doubled to form a byte address. Three small counters set the setup, strobe and hold lengths of each bus cycle. Words fetched by read cycles are returned with a slot number. A write-protect input holds the block in a protected state in which nothing is started.

The controller is a five-state machine. The states and their transitions are:
- IDLE goes to SETUP when a request is accepted.
- SETUP goes to PULSE when the setup count expires.
- PULSE goes to HOLD when the strobe count expires.
- HOLD goes to SETUP for the next step, or to DONE after the last step.
- DONE goes to IDLE after one cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: In IDLE, with protect low and a valid opcode (0 to 5), a request with `req_valid` high is accepted. `req_ack` is high in that same cycle and `busy` is high from the next cycle. At the end of the sequence, `done` is high for exactly one cycle. After that, `busy` is 0 and `ctrl_state` is 0 (ready).
- R2: Program (opcode 2) issues four writes in this order: 0xAA to word 0x555, 0x55 to word 0x2AA, 0xA0 to word 0x555, and then `req_wdata` to the target offset.
- R3: Sector erase (opcode 3) issues six writes in this order: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, and then 0x30 to the target offset.
- R4: Chip erase (opcode 4) issues the same first five writes as sector erase, followed by 0x10 to word 0x555.
- R5: Return-to-read (opcode 1) issues a single write of 0xF0 to the bank base, which is word 0.
- R6: Read-ID (opcode 0) issues the writes AA@555, 55@2AA and 90@555. It then runs four read cycles at words 0x000, 0x001, 0x00E and 0x00F. Each word read is presented on `rd_data` with `rd_valid` high, and `rd_slot` is 0 to 3 in read order.
- R7: CFI query (opcode 5) issues a single write of 0x98 to word 0x055. It then runs four reads at words 0x010 to 0x013, with `rd_slot` 0 to 3.
- R8: Bus cycle timing is as follows:
  - `bus_ce_n` is low for the whole of every bus cycle.
  - Each strobe is preceded by `cfg_setup`+1 cycles and followed by `cfg_hold`+1 cycles with no strobe.
  - Each strobe is low for `cfg_pulse`+1 cycles.
  - Write-enable and output-enable are never low together.
  - Address and data stay stable while a strobe is low.
- R9: A request made while `busy` is high is refused: `req_rej` is high and `req_ack` is low. The sequence in progress still completes unchanged.
- R10: While idle with `cfg_wprot` high, `ctrl_state` is 2 (protected) and every request is refused with `req_rej`. No strobe occurs in this state. A sequence already running when protect rises runs to its end.
- R11: `bus_addr` is formed as {`cfg_bank_sel`, offset}, using the bank select latched when the request is accepted. For a command word, the offset is word×2 when `cfg_wide`=1 and the word unshifted when `cfg_wide`=0. For a target write, the offset is `req_addr` unchanged.
- R12: Opcodes 6 and 7 are refused with `req_rej` and cause no bus activity.
- R13: After reset, `busy`, `done`, `req_ack` and `rd_valid` are 0, the three bus enables are high, and `ctrl_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Opcode (0 id, 1 return-to-read, 2 program, 3 sector erase, 4 chip erase, 5 CFI) |
| req_addr | input | BANK_W | Target byte offset within the bank |
| req_wdata | input | DATA_W | Word to program |
| req_ack | output | 1 | Request accepted this cycle |
| req_rej | output | 1 | Request refused this cycle |
| cfg_bank_sel | input | 2 | Bank region select |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit |
| cfg_wprot | input | 1 | Write protect |
| cfg_setup | input | CNT_W | Setup count |
| cfg_pulse | input | CNT_W | Strobe count |
| cfg_hold | input | CNT_W | Hold count |
| bus_addr | output | BANK_W+2 | Device byte address |
| bus_dout | output | DATA_W | Write data to device |
| bus_din | input | DATA_W | Read data from device |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ctrl_state | output | 2 | 0 ready, 1 busy, 2 protected |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| rd_slot | output | 2 | Index of the read within its sequence |

## Verification
Every opcode is run at least once, and the logged write list is compared entry by entry. This distinguishes the unlock prefix, the third-cycle code and the final target or command write between operations. Program is run in both width modes and in different banks, which separates the shifted and unshifted command addresses from the unshifted target offset. Non-zero timing counts are used to tell the setup, strobe and hold lengths apart. Other runs send a request into a running sequence, raise protect both while idle and during a sequence, and offer an undefined opcode, to show that these requests are refused without changing the bus traffic.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ_ID      = 3'd0,
        OP_RESET        = 3'd1,
        OP_PROGRAM      = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_CHIP_ERASE   = 3'd4,
        OP_CFI_QUERY    = 3'd5
    } nor_op_e;

    typedef enum logic [1:0] {
        CS_READY     = 2'd0,
        CS_BUSY      = 2'd1,
        CS_PROTECTED = 2'd2
    } ctrl_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_DONE
    } fsm_e;

    localparam int STEP_IDX_W = 3;
    localparam int CMD_WORD_W = 12;

    typedef struct packed {
        logic                  is_read;
        logic                  to_target;
        logic                  use_wdata;
        logic                  last;
        logic [1:0]            slot;
        logic [CMD_WORD_W-1:0] word;
        logic [7:0]            code;
    } step_t;

endpackage

// File: rtl/nor_seq_rom.sv
module nor_seq_rom
    import nor_seq_pkg::*;
(
    input  nor_op_e                 op,
    input  logic [STEP_IDX_W-1:0]   idx,
    output step_t                   step
);

    function automatic step_t mk(input logic rd, input logic tgt, input logic wd,
                                 input logic [CMD_WORD_W-1:0] w, input logic [7:0] c,
                                 input logic [1:0] s);
        step_t r;
        r.is_read   = rd;
        r.to_target = tgt;
        r.use_wdata = wd;
        r.last      = 1'b0;
        r.slot      = s;
        r.word      = w;
        r.code      = c;
        return r;
    endfunction

    logic [STEP_IDX_W-1:0] nsteps;
    logic [STEP_IDX_W-1:0] rel_id;
    logic [STEP_IDX_W-1:0] rel_cfi;
    step_t                 raw;

    assign rel_id  = idx - STEP_IDX_W'(3);
    assign rel_cfi = idx - STEP_IDX_W'(1);

    always_comb begin
        raw    = '0;
        nsteps = STEP_IDX_W'(1);
        unique case (op)
            OP_READ_ID: begin
                nsteps = STEP_IDX_W'(7);
                case (idx)
                    3'd0:    raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'hAA, 2'd0);
                    3'd1:    raw = mk(1'b0, 1'b0, 1'b0, 12'h2AA, 8'h55, 2'd0);
                    3'd2:    raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'h90, 2'd0);
                    default: raw = mk(1'b1, 1'b0, 1'b0,
                                      {8'h00, rel_id[1], rel_id[1], rel_id[1], rel_id[0]},
                                      8'h00, rel_id[1:0]);
                endcase
            end
            OP_RESET: begin
                nsteps = STEP_IDX_W'(1);
                raw    = mk(1'b0, 1'b0, 1'b0, 12'h000, 8'hF0, 2'd0);
            end
            OP_PROGRAM: begin
                nsteps = STEP_IDX_W'(4);
                case (idx)
                    3'd0:    raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'hAA, 2'd0);
                    3'd1:    raw = mk(1'b0, 1'b0, 1'b0, 12'h2AA, 8'h55, 2'd0);
                    3'd2:    raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'hA0, 2'd0);
                    default: raw = mk(1'b0, 1'b1, 1'b1, 12'h000, 8'h00, 2'd0);
                endcase
            end
            OP_SECTOR_ERASE, OP_CHIP_ERASE: begin
                nsteps = STEP_IDX_W'(6);
                case (idx)
                    3'd0, 3'd3: raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'hAA, 2'd0);
                    3'd1, 3'd4: raw = mk(1'b0, 1'b0, 1'b0, 12'h2AA, 8'h55, 2'd0);
                    3'd2:       raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'h80, 2'd0);
                    default: begin
                        if (op == OP_SECTOR_ERASE)
                            raw = mk(1'b0, 1'b1, 1'b0, 12'h000, 8'h30, 2'd0);
                        else
                            raw = mk(1'b0, 1'b0, 1'b0, 12'h555, 8'h10, 2'd0);
                    end
                endcase
            end
            OP_CFI_QUERY: begin
                nsteps = STEP_IDX_W'(5);
                if (idx == 3'd0)
                    raw = mk(1'b0, 1'b0, 1'b0, 12'h055, 8'h98, 2'd0);
                else
                    raw = mk(1'b1, 1'b0, 1'b0, 12'h010 + CMD_WORD_W'(rel_cfi), 8'h00, rel_cfi[1:0]);
            end
            default: raw = '0;
        endcase
    end

    always_comb begin
        step      = raw;
        step.last = (idx == nsteps - STEP_IDX_W'(1));
    end

endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/nor_seq_addr.sv
module nor_seq_addr
    import nor_seq_pkg::*;
#(
    parameter int BANK_W = 20
) (
    input  logic [1:0]        bank,
    input  logic              wide,
    input  step_t             step,
    input  logic [BANK_W-1:0] target,
    output logic [BANK_W+1:0] addr
);

    logic [BANK_W-1:0] cmd_off;
    logic [BANK_W-1:0] off;

    assign cmd_off = BANK_W'(step.word) << wide;
    assign off     = step.to_target ? target : cmd_off;
    assign addr    = {bank, off};

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int BANK_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic              req_rej,
    input  logic [1:0]        cfg_bank_sel,
    input  logic              cfg_wide,
    input  logic              cfg_wprot,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_hold,
    output logic [BANK_W+1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_ce_n,
    output logic              bus_we_n,
    output logic              bus_oe_n,
    output logic              busy,
    output logic              done,
    output logic [1:0]        ctrl_state,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [1:0]        rd_slot
);

    fsm_e                  state, state_nx;
    nor_op_e               op_q;
    logic [STEP_IDX_W-1:0] idx_q;
    logic [BANK_W-1:0]     target_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [1:0]            bank_q;
    logic                  wide_q;
    step_t                 step;
    logic                  t_exp;
    logic                  t_load;
    logic [CNT_W-1:0]      t_val;
    logic                  accept;
    logic                  op_ok;

    assign op_ok  = (req_op <= 3'd5);
    assign accept = req_valid && (state == ST_IDLE) && !cfg_wprot && op_ok;

    nor_seq_rom u_rom (
        .op   (op_q),
        .idx  (idx_q),
        .step (step)
    );

    nor_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    nor_seq_addr #(.BANK_W(BANK_W)) u_addr (
        .bank   (bank_q),
        .wide   (wide_q),
        .step   (step),
        .target (target_q),
        .addr   (bus_addr)
    );

    // next state and counter reload
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = cfg_setup;
        unique case (state)
            ST_IDLE: if (accept) begin
                state_nx = ST_SETUP;
                t_load   = 1'b1;
                t_val    = cfg_setup;
            end
            ST_SETUP: if (t_exp) begin
                state_nx = ST_PULSE;
                t_load   = 1'b1;
                t_val    = cfg_pulse;
            end
            ST_PULSE: if (t_exp) begin
                state_nx = ST_HOLD;
                t_load   = 1'b1;
                t_val    = cfg_hold;
            end
            ST_HOLD: if (t_exp) begin
                if (step.last) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_SETUP;
                    t_load   = 1'b1;
                    t_val    = cfg_setup;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_RESET;
            idx_q    <= '0;
            target_q <= '0;
            wdata_q  <= '0;
            bank_q   <= '0;
            wide_q   <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_slot  <= '0;
        end else begin
            state    <= state_nx;
            rd_valid <= 1'b0;
            if (accept) begin
                op_q     <= nor_op_e'(req_op);
                idx_q    <= '0;
                target_q <= req_addr;
                wdata_q  <= req_wdata;
                bank_q   <= cfg_bank_sel;
                wide_q   <= cfg_wide;
            end
            if (state == ST_PULSE && t_exp && step.is_read) begin
                rd_data  <= bus_din;
                rd_valid <= 1'b1;
                rd_slot  <= step.slot;
            end
            if (state == ST_HOLD && t_exp && !step.last)
                idx_q <= idx_q + STEP_IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        bus_ce_n   = 1'b1;
        bus_we_n   = 1'b1;
        bus_oe_n   = 1'b1;
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        req_ack    = accept;
        req_rej    = req_valid && !accept;
        bus_dout   = step.use_wdata ? wdata_q : DATA_W'(step.code);
        unique case (state)
            ST_IDLE, ST_DONE: ;
            ST_SETUP, ST_HOLD: bus_ce_n = 1'b0;
            ST_PULSE: begin
                bus_ce_n = 1'b0;
                bus_we_n = step.is_read;
                bus_oe_n = !step.is_read;
            end
        endcase
        if (busy)
            ctrl_state = CS_BUSY;
        else if (cfg_wprot)
            ctrl_state = CS_PROTECTED;
        else
            ctrl_state = CS_READY;
    end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int BANK_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ack,
    input logic              req_rej,
    input logic [BANK_W+1:0] bus_addr,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_ce_n,
    input logic              bus_we_n,
    input logic              bus_oe_n,
    input logic              busy,
    input logic              done,
    input logic [1:0]        ctrl_state
);

    AST_ACK_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_oe_n) |-> !bus_ce_n); // R8

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n)); // R8

    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_dout))); // R8

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |-> (!req_ack && req_rej)); // R9

    AST_PROTECT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == 2'd2) |-> (bus_we_n && bus_oe_n && !req_ack)); // R10

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.BANK_W(BANK_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .req_rej    (req_rej),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_ce_n   (bus_ce_n),
    .bus_we_n   (bus_we_n),
    .bus_oe_n   (bus_oe_n),
    .busy       (busy),
    .done       (done),
    .ctrl_state (ctrl_state)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;

    localparam int BANK_W = 20;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;
    localparam int AW     = BANK_W + 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [BANK_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ack, req_rej;
    logic [1:0]        cfg_bank_sel = '0;
    logic              cfg_wide = 1'b1;
    logic              cfg_wprot = 1'b0;
    logic [CNT_W-1:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0;
    logic [AW-1:0]     bus_addr;
    logic [DATA_W-1:0] bus_dout, bus_din;
    logic              bus_ce_n, bus_we_n, bus_oe_n;
    logic              busy, done;
    logic [1:0]        ctrl_state;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic [1:0]        rd_slot;

    nor_cmd_seq #(.BANK_W(BANK_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .req_rej(req_rej),
        .cfg_bank_sel(cfg_bank_sel), .cfg_wide(cfg_wide), .cfg_wprot(cfg_wprot),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .busy(busy), .done(done), .ctrl_state(ctrl_state),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_slot(rd_slot)
    );

    function automatic logic [DATA_W-1:0] model(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign bus_din = bus_oe_n ? '0 : model(bus_addr);

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bus monitor
    logic [AW-1:0]     w_addr [0:15];
    logic [DATA_W-1:0] w_data [0:15];
    int                wn = 0;
    logic [DATA_W-1:0] r_data [0:7];
    logic [1:0]        r_slot [0:7];
    int                rn = 0;
    int                act = 0;
    logic              wlow_prev = 1'b0;
    logic [AW-1:0]     cur_a;
    logic [DATA_W-1:0] cur_d;

    always @(negedge clk) begin
        if (!bus_we_n) begin
            cur_a = bus_addr;
            cur_d = bus_dout;
        end
        if (bus_we_n && wlow_prev && wn < 16) begin
            w_addr[wn] = cur_a;
            w_data[wn] = cur_d;
            wn++;
        end
        if (!bus_ce_n || !bus_we_n || !bus_oe_n) act++;
        if (rd_valid && rn < 8) begin
            r_data[rn] = rd_data;
            r_slot[rn] = rd_slot;
            rn++;
        end
        wlow_prev = !bus_we_n;
    end

    logic [AW-1:0]     exp_a [0:15];
    logic [DATA_W-1:0] exp_d [0:15];
    int                exp_n;
    logic              last_ack, last_rej;

    function automatic logic [AW-1:0] ea(input logic [1:0] b, input logic w, input logic [11:0] word);
        logic [12:0] t;
        t = w ? {word, 1'b0} : {1'b0, word};
        return {b, BANK_W'(t)};
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic cmp_writes(input string req);
        check(wn == exp_n, req, "write count", wn, exp_n);
        for (int i = 0; i < exp_n && i < wn; i++) begin
            check(w_addr[i] == exp_a[i], req, $sformatf("write %0d addr", i), 32'(w_addr[i]), 32'(exp_a[i]));
            check(w_data[i] == exp_d[i], req, $sformatf("write %0d data", i), 32'(w_data[i]), 32'(exp_d[i]));
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [BANK_W-1:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk);
        wn = 0; rn = 0; act = 0; exp_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #1;
        last_ack = req_ack;
        last_rej = req_rej;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done seen", 32'(done), 32'd1);
        @(negedge clk);
    endtask

    task automatic unlock(input logic [1:0] b, input logic w);
        push(ea(b, w, 12'h555), 16'h00AA);
        push(ea(b, w, 12'h2AA), 16'h0055);
    endtask

    task automatic t_reset_state;
        check(busy == 0 && done == 0 && req_ack == 0 && rd_valid == 0, "R13", "flags",
              {busy, done, req_ack, rd_valid}, 0);
        check({bus_ce_n, bus_we_n, bus_oe_n} == 3'b111, "R13", "enables", {bus_ce_n, bus_we_n, bus_oe_n}, 3'b111);
        check(ctrl_state == 2'd0, "R13", "ctrl_state", ctrl_state, 0);
    endtask

    task automatic t_program(input logic [1:0] b, input logic w, input logic [BANK_W-1:0] tgt,
                             input logic [DATA_W-1:0] d);
        cfg_bank_sel = b; cfg_wide = w;
        issue(3'd2, tgt, d);
        check(last_ack == 1 && last_rej == 0, "R1", "ack on accept", {last_ack, last_rej}, 2'b10);
        check(busy == 1, "R1", "busy after accept", busy, 1);
        wait_done("R2");
        check(done == 0 && busy == 0 && ctrl_state == 0, "R1", "done single, ready after",
              {done, busy, ctrl_state}, 0);
        unlock(b, w);
        push(ea(b, w, 12'h555), 16'h00A0);
        push({b, tgt}, d);
        cmp_writes(w ? "R2 R11 wide" : "R2 R11 narrow");
    endtask

    task automatic t_erase(input logic sector, input logic [1:0] b, input logic w, input logic [BANK_W-1:0] tgt);
        cfg_bank_sel = b; cfg_wide = w;
        issue(sector ? 3'd3 : 3'd4, tgt, 16'hFFFF);
        wait_done(sector ? "R3" : "R4");
        unlock(b, w);
        push(ea(b, w, 12'h555), 16'h0080);
        unlock(b, w);
        if (sector) push({b, tgt}, 16'h0030);
        else        push(ea(b, w, 12'h555), 16'h0010);
        cmp_writes(sector ? "R3" : "R4");
    endtask

    task automatic t_return_read(input logic [1:0] b);
        cfg_bank_sel = b;
        issue(3'd1, 20'h12345, 16'h0);
        wait_done("R5");
        push({b, {BANK_W{1'b0}}}, 16'h00F0);
        cmp_writes("R5");
    endtask

    task automatic t_reads(input logic cfi, input logic [1:0] b, input logic w);
        logic [11:0] words [0:3];
        string req;
        req = cfi ? "R7" : "R6";
        cfg_bank_sel = b; cfg_wide = w;
        issue(cfi ? 3'd5 : 3'd0, 20'h0, 16'h0);
        wait_done(req);
        if (cfi) begin
            push(ea(b, w, 12'h055), 16'h0098);
            words[0] = 12'h010; words[1] = 12'h011; words[2] = 12'h012; words[3] = 12'h013;
        end else begin
            unlock(b, w);
            push(ea(b, w, 12'h555), 16'h0090);
            words[0] = 12'h000; words[1] = 12'h001; words[2] = 12'h00E; words[3] = 12'h00F;
        end
        cmp_writes(req);
        check(rn == 4, req, "read count", rn, 4);
        for (int i = 0; i < 4 && i < rn; i++) begin
            check(r_data[i] == model(ea(b, w, words[i])), req, $sformatf("read %0d data", i),
                  32'(r_data[i]), 32'(model(ea(b, w, words[i]))));
            check(r_slot[i] == 2'(i), req, $sformatf("read %0d slot", i), r_slot[i], i);
        end
    endtask

    task automatic t_timing;
        int pre = 0, lo = 0, gap = 0, ce_hi = 0;
        cfg_setup = 4'd2; cfg_pulse = 4'd3; cfg_hold = 4'd1;
        cfg_bank_sel = 2'd0; cfg_wide = 1'b1;
        issue(3'd2, 20'h00100, 16'hBEEF);
        while (bus_we_n && pre < 100) begin
            if (!bus_ce_n) pre++;
            @(negedge clk);
        end
        while (!bus_we_n && lo < 100) begin
            lo++;
            @(negedge clk);
        end
        while (bus_we_n && gap < 100) begin
            if (!bus_ce_n) gap++; else ce_hi++;
            @(negedge clk);
        end
        check(pre == 3, "R8", "setup cycles", pre, 3);
        check(lo == 4, "R8", "strobe cycles", lo, 4);
        check(gap == 5, "R8", "hold+setup cycles", gap, 5);
        check(ce_hi == 0, "R8", "ce high between cycles", ce_hi, 0);
        wait_done("R8");
        unlock(2'd0, 1'b1);
        push(ea(2'd0, 1'b1, 12'h555), 16'h00A0);
        push({2'd0, 20'h00100}, 16'hBEEF);
        cmp_writes("R8");
        cfg_setup = 0; cfg_pulse = 0; cfg_hold = 0;
    endtask

    task automatic t_busy_reject;
        cfg_bank_sel = 2'd3; cfg_wide = 1'b1;
        issue(3'd2, 20'h00400, 16'h1234);
        @(negedge clk); @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_addr = 20'h0; req_wdata = 16'h0;
        #1;
        check(req_rej == 1 && req_ack == 0, "R9", "refused while busy", {req_ack, req_rej}, 2'b01);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R9");
        unlock(2'd3, 1'b1);
        push(ea(2'd3, 1'b1, 12'h555), 16'h00A0);
        push({2'd3, 20'h00400}, 16'h1234);
        cmp_writes("R9");
    endtask

    task automatic t_protect;
        cfg_bank_sel = 2'd0; cfg_wide = 1'b1;
        cfg_wprot = 1'b1;
        @(negedge clk);
        check(ctrl_state == 2'd2, "R10", "protected state", ctrl_state, 2);
        issue(3'd2, 20'h00010, 16'h5555);
        check(last_ack == 0 && last_rej == 1, "R10", "refused when protected", {last_ack, last_rej}, 2'b01);
        repeat (20) @(negedge clk);
        check(act == 0, "R10", "no bus activity", act, 0);
        check(busy == 0, "R10", "stays idle", busy, 0);
        cfg_wprot = 1'b0;
        issue(3'd1, 20'h0, 16'h0);
        @(negedge clk);
        cfg_wprot = 1'b1;
        wait_done("R10");
        push({2'd0, {BANK_W{1'b0}}}, 16'h00F0);
        cmp_writes("R10");
        check(ctrl_state == 2'd2, "R10", "protected after sequence", ctrl_state, 2);
        cfg_wprot = 1'b0;
    endtask

    task automatic t_bad_op;
        issue(3'd6, 20'h0, 16'h0);
        check(last_ack == 0 && last_rej == 1, "R12", "opcode 6 refused", {last_ack, last_rej}, 2'b01);
        issue(3'd7, 20'h0, 16'h0);
        check(last_ack == 0 && last_rej == 1, "R12", "opcode 7 refused", {last_ack, last_rej}, 2'b01);
        repeat (10) @(negedge clk);
        check(act == 0 && busy == 0, "R12", "no activity", {act[30:0], busy}, 0);
    endtask

    bit finished = 0;

    initial begin
        #600000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_program(2'd1, 1'b1, 20'h0ABCD, 16'hC0DE);
        t_program(2'd2, 1'b0, 20'h00321, 16'h00A5);
        t_erase(1'b1, 2'd0, 1'b1, 20'h40000);
        t_erase(1'b0, 2'd3, 1'b0, 20'h0);
        t_return_read(2'd2);
        t_reads(1'b0, 2'd1, 1'b1);
        t_reads(1'b1, 2'd0, 1'b0);
        t_timing();
        t_busy_reject();
        t_protect();
        t_bad_op();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule